// File: doc/BRIEF.md
# Radio State Sequencer

This block is the power and operating-state controller of a sub-GHz transceiver. A host sends one-byte commands, and the block moves the radio between five states: sleep, off, on, receive and transmit. Moves that touch the RF path do not happen in one step. The controller walks an ordered list of hardware actions and drives the control outputs one at a time. On the way it waits for completion handshakes from the analog side, counts a programmable settle delay, and changes the reported state only when the last action has finished.

Which list runs depends on both the source state and the target state. A receive command issued while already receiving first takes the receive chain down and then retunes it. Leaving receive captures the signal-strength reading before anything is powered off. Leaving transmit ramps the PA down before any other action. The datapath reports end of frame, and the controller then either returns to the on state or turns straight around into the opposite direction. It can raise an interrupt when this happens. In streaming operation it ignores end of frame.

Top module: `radio_state_seq`

## Requirements
- R1: After reset the state output reads off and cmd_ready is high. The error flag, the interrupt and every control output are low. State codes are sleep=0, off=1, on=2, receive=3, transmit=4.
- R2: Opcodes are 0xB0 off, 0xB1 on, 0xBA sleep, 0xB2 receive, 0xB5 transmit and 0xC8 hardware reset. Sleep is taken from off or on. Off is taken from on only. On is taken from off or on directly, with the state valid one cycle after the command. Receive and transmit are taken from on, receive or transmit.
- R3: A command not allowed in the current state, or an unknown opcode, leaves the state and the outputs unchanged and sets the sticky error flag.
- R4: From on to receive, events occur in this order: synth power, receiver power, channel load, bandwidth set, VCO calibration start, then (after the calibration done input and the settle delay) digital receive enable and external LNA enable if configured. The state then reads receive.
- R5: From on to transmit, events occur in this order: synth power, channel load, bandwidth set, VCO calibration start, then (after done and settle) digital transmit enable, external PA enable if configured, and PA ramp-up start. After the ramp done input the state reads transmit.
- R6: From transmit to on, events occur in this order: PA ramp-down start, then (after ramp done) the external PA enable drops, the digital transmit enable drops and the synth powers down.
- R7: From receive to on, the rssi input is captured on rssi_hold before the LNA enable drops. The digital receive enable and the receiver power then drop, and then the synth powers down.
- R8: A receive command while receiving drops the LNA enable and then the receive blocks, with the synth kept on. It then reruns receiver power, channel load, bandwidth, calibration, settle, digital enable and LNA enable, and ends in receive.
- R9: End of frame in transmit or receive returns the radio to on, or to the opposite direction when the matching turnaround input is set. It pulses eof_irq for one cycle when eof_irq_en is set.
- R10: With stream_mode high, end-of-frame inputs are ignored. Receive or transmit persists until an on command arrives.
- R11: Hardware reset from any state, including during a sequence, forces sleep and clears every control output at once. In sleep, cmd_ready is low. cs_wake or wake_timer moves sleep to off.
- R12: cmd_ready is low while a sequence runs. A command that arrives then, or in sleep (other than hardware reset), is dropped and sets the error flag.
- R13: The gap between calibration done and digital enable grows by exactly one cycle for each unit of settle_cycles.
- R14: If a calibration or ramp done input does not arrive within TMO_CYC cycles, the error flag sets, every control output clears and the state becomes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_byte_i | input | 8 | Command opcode |
| cs_wake_i | input | 1 | Chip-select asserted, wakes from sleep |
| wake_timer_i | input | 1 | Wake timer expired, wakes from sleep |
| stream_mode_i | input | 1 | Streaming operation, disables end-of-frame moves |
| turn_rx2tx_i | input | 1 | After receive end of frame go to transmit |
| turn_tx2rx_i | input | 1 | After transmit end of frame go to receive |
| ext_pa_cfg_i | input | 1 | Use external PA enable |
| ext_lna_cfg_i | input | 1 | Use external LNA enable |
| eof_irq_en_i | input | 1 | Raise interrupt on end of frame |
| settle_cycles_i | input | SETTLE_W | Synthesizer settle delay in cycles |
| eof_tx_i | input | 1 | Packet transmission complete |
| eof_rx_i | input | 1 | Valid packet received |
| vco_done_i | input | 1 | VCO calibration complete |
| ramp_done_i | input | 1 | PA ramp (up or down) complete |
| rssi_i | input | RSSI_W | Live signal-strength measurement |
| state_o | output | 3 | Current state code |
| cmd_ready_o | output | 1 | Ready for a command |
| err_o | output | 1 | Sticky error flag |
| eof_irq_o | output | 1 | End-of-frame interrupt pulse |
| synth_pwr_o | output | 1 | Synthesizer power |
| rx_pwr_o | output | 1 | Receive chain power |
| chan_load_o | output | 1 | Load channel word (pulse) |
| bw_set_o | output | 1 | Set synth loop bandwidth (pulse) |
| vco_cal_start_o | output | 1 | Start VCO calibration (pulse) |
| dig_rx_en_o | output | 1 | Digital receive enable |
| dig_tx_en_o | output | 1 | Digital transmit clocks enable |
| ext_lna_o | output | 1 | External LNA enable |
| ext_pa_o | output | 1 | External PA enable |
| pa_ramp_up_o | output | 1 | Start PA ramp-up (pulse) |
| pa_ramp_down_o | output | 1 | Start PA ramp-down (pulse) |
| rssi_hold_o | output | RSSI_W | Signal strength captured when leaving receive |

## Verification
The bench logs the order in which control outputs rise and fall and compares it with the expected list for each origin and target. A design that shared one list for every move into receive would put the synth event into a retune, or would drop the LNA before capturing the signal strength. A hardware reset sent in the middle of a sequence catches a design that lets a half-powered synth run on into sleep. A frame end in streaming mode catches a design that still returns to on. A silent calibration handshake catches a design that hangs instead of timing out. Two settle values are compared to expose an off-by-one or an ignored delay count.

// File: rtl/rss_pkg.sv
// Shared types for the radio state sequencer.
// Assumes: state codes are visible to software and must not be renumbered.
package rss_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_OFF   = 3'd1,
        ST_ON    = 3'd2,
        ST_RX    = 3'd3,
        ST_TX    = 3'd4
    } rs_state_t;

    localparam logic [7:0] OP_OFF   = 8'hB0;
    localparam logic [7:0] OP_ON    = 8'hB1;
    localparam logic [7:0] OP_RX    = 8'hB2;
    localparam logic [7:0] OP_TX    = 8'hB5;
    localparam logic [7:0] OP_SLEEP = 8'hBA;
    localparam logic [7:0] OP_HWRST = 8'hC8;

    typedef enum logic [4:0] {
        S_IDLE, S_RSSI, S_LNA_OFF, S_RX_DN, S_RAMP_DN, S_RAMP_DN_W,
        S_PA_OFF, S_TXCLK, S_SYN_DN, S_SYN_UP, S_RX_UP, S_CHAN, S_BW,
        S_VCO, S_VCO_W, S_SETL0, S_SETL_W, S_DIG, S_EXT, S_RAMP_UP,
        S_RAMP_UP_W, S_DONE, S_FAIL
    } step_t;

endpackage

// File: rtl/rss_cmd_check.sv
// Command legality table: for an opcode and the current state, says
// whether the command is taken, whether it needs a hardware sequence,
// and which state it aims at. Pure combinational; hardware reset is
// handled by the caller and is reported here as not legal.
module rss_cmd_check
    import rss_pkg::*;
(
    input  logic [7:0] op_i,
    input  rs_state_t  cur_i,
    output logic       legal_o,
    output logic       need_seq_o,
    output rs_state_t  target_o
);

    logic rf_active;
    assign rf_active = (cur_i == ST_RX) || (cur_i == ST_TX);

    // Decode the opcode against the current state.
    always_comb begin
        legal_o    = 1'b0;
        need_seq_o = 1'b0;
        target_o   = cur_i;
        case (op_i)
            OP_SLEEP: begin
                legal_o  = (cur_i == ST_OFF) || (cur_i == ST_ON);
                target_o = ST_SLEEP;
            end
            OP_OFF: begin
                legal_o  = (cur_i == ST_ON);
                target_o = ST_OFF;
            end
            OP_ON: begin
                legal_o    = (cur_i != ST_SLEEP);
                need_seq_o = rf_active;
                target_o   = ST_ON;
            end
            OP_RX, OP_TX: begin
                legal_o    = rf_active || (cur_i == ST_ON);
                need_seq_o = 1'b1;
                target_o   = (op_i == OP_RX) ? ST_RX : ST_TX;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rss_wait_timer.sv
// Loadable down-counter used for both the settle delay and the handshake
// timeout. Loads on load_i, then counts down to zero and holds there.
module rss_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Load or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R13: the delay shrinks by exactly one per cycle once loaded.
    p_count_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rss_seq_engine.sv
// Step engine: runs the ordered power, tune and ramp actions for a move
// from one RF-related state to another. Levels change on the edge that
// leaves a step; pulses are high for the one cycle spent in a step.
// Assumes the configuration inputs are stable while a sequence runs.
module rss_seq_engine
    import rss_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int TMO_CYC  = 64,
    parameter int RSSI_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort_i,
    input  logic                start_i,
    input  rs_state_t           from_i,
    input  rs_state_t           to_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                cfg_pa_i,
    input  logic                cfg_lna_i,
    input  logic                vco_done_i,
    input  logic                ramp_done_i,
    input  logic [RSSI_W-1:0]   rssi_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output rs_state_t           dest_o,
    output logic                synth_o,
    output logic                rx_pwr_o,
    output logic                dig_rx_o,
    output logic                dig_tx_o,
    output logic                lna_o,
    output logic                pa_o,
    output logic                chan_o,
    output logic                bw_o,
    output logic                vco_start_o,
    output logic                ramp_up_o,
    output logic                ramp_dn_o,
    output logic [RSSI_W-1:0]   rssi_q_o
);

    localparam int TW = $clog2(TMO_CYC + 1);
    localparam int CW = (TW > SETTLE_W) ? TW : SETTLE_W;

    step_t         step_q, step_n;
    rs_state_t     from_q, dest_q;
    logic          tmr_zero, tmr_load, retune, to_rx;
    logic [CW-1:0] tmr_val;

    assign retune = (from_q == ST_RX) && (dest_q == ST_RX);
    assign to_rx  = (dest_q == ST_RX);

    assign tmr_load = (step_q == S_VCO) || (step_q == S_SETL0) ||
                      (step_q == S_RAMP_UP) || (step_q == S_RAMP_DN);
    assign tmr_val  = (step_q == S_SETL0) ? CW'(settle_i) : CW'(TMO_CYC);

    rss_wait_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    // Pick the next step of the ordered action list.
    always_comb begin
        step_n = step_q;
        case (step_q)
            S_IDLE: if (start_i) begin
                if (from_i == ST_TX)      step_n = S_RAMP_DN;
                else if (from_i == ST_RX) step_n = (to_i == ST_RX) ? S_LNA_OFF : S_RSSI;
                else                      step_n = S_SYN_UP;
            end
            S_RSSI:      step_n = S_LNA_OFF;
            S_LNA_OFF:   step_n = S_RX_DN;
            S_RX_DN:     step_n = retune ? S_SYN_UP : S_SYN_DN;
            S_RAMP_DN:   step_n = S_RAMP_DN_W;
            S_RAMP_DN_W: if (ramp_done_i) step_n = S_PA_OFF;
                         else if (tmr_zero) step_n = S_FAIL;
            S_PA_OFF:    step_n = S_TXCLK;
            S_TXCLK:     step_n = S_SYN_DN;
            S_SYN_DN:    step_n = (dest_q == ST_ON) ? S_DONE : S_SYN_UP;
            S_SYN_UP:    step_n = to_rx ? S_RX_UP : S_CHAN;
            S_RX_UP:     step_n = S_CHAN;
            S_CHAN:      step_n = S_BW;
            S_BW:        step_n = S_VCO;
            S_VCO:       step_n = S_VCO_W;
            S_VCO_W:     if (vco_done_i) step_n = S_SETL0;
                         else if (tmr_zero) step_n = S_FAIL;
            S_SETL0:     step_n = S_SETL_W;
            S_SETL_W:    if (tmr_zero) step_n = S_DIG;
            S_DIG:       step_n = S_EXT;
            S_EXT:       step_n = to_rx ? S_DONE : S_RAMP_UP;
            S_RAMP_UP:   step_n = S_RAMP_UP_W;
            S_RAMP_UP_W: if (ramp_done_i) step_n = S_DONE;
                         else if (tmr_zero) step_n = S_FAIL;
            default:     step_n = S_IDLE;
        endcase
    end

    // Advance the step and apply the level changes of the step being left.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            step_q   <= S_IDLE;
            from_q   <= ST_ON;
            dest_q   <= ST_ON;
            synth_o  <= 1'b0;
            rx_pwr_o <= 1'b0;
            dig_rx_o <= 1'b0;
            dig_tx_o <= 1'b0;
            lna_o    <= 1'b0;
            pa_o     <= 1'b0;
            if (!rst_n) rssi_q_o <= '0;
        end else begin
            step_q <= step_n;
            if (step_q == S_IDLE && start_i) begin
                from_q <= from_i;
                dest_q <= to_i;
            end
            case (step_q)
                S_RSSI:    rssi_q_o <= rssi_i;
                S_LNA_OFF: lna_o    <= 1'b0;
                S_RX_DN: begin
                    rx_pwr_o <= 1'b0;
                    dig_rx_o <= 1'b0;
                end
                S_PA_OFF:  pa_o     <= 1'b0;
                S_TXCLK:   dig_tx_o <= 1'b0;
                S_SYN_DN:  synth_o  <= 1'b0;
                S_SYN_UP:  synth_o  <= 1'b1;
                S_RX_UP:   rx_pwr_o <= 1'b1;
                S_DIG:     if (to_rx) dig_rx_o <= 1'b1; else dig_tx_o <= 1'b1;
                S_EXT:     if (to_rx) lna_o <= cfg_lna_i; else pa_o <= cfg_pa_i;
                S_FAIL: begin
                    synth_o  <= 1'b0;
                    rx_pwr_o <= 1'b0;
                    dig_rx_o <= 1'b0;
                    dig_tx_o <= 1'b0;
                    lna_o    <= 1'b0;
                    pa_o     <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy_o      = (step_q != S_IDLE);
    assign done_o      = (step_q == S_DONE);
    assign fail_o      = (step_q == S_FAIL);
    assign dest_o      = dest_q;
    assign chan_o      = (step_q == S_CHAN);
    assign bw_o        = (step_q == S_BW);
    assign vco_start_o = (step_q == S_VCO);
    assign ramp_up_o   = (step_q == S_RAMP_UP);
    assign ramp_dn_o   = (step_q == S_RAMP_DN);

    // R4: the external LNA is only enabled on a powered receive chain.
    p_lna_on_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lna_o |-> rx_pwr_o);
    // R4: calibration is only started with the synthesizer powered.
    p_vco_synth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vco_start_o |-> synth_o);
    // R5: the external PA enable is settled before the ramp starts.
    p_pa_before_ramp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up_o |-> (pa_o == cfg_pa_i));
    // R6: receive and transmit digital paths never run together.
    p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dig_rx_o, dig_tx_o}));

endmodule

// File: rtl/radio_state_seq.sv
// Top of the radio state sequencer. Holds the reported state, takes
// host commands and end-of-frame events, and hands RF moves to the
// step engine. Assumes one command byte per cycle at most and
// synchronous, single-cycle handshake pulses.
module radio_state_seq
    import rss_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int TMO_CYC  = 64,
    parameter int RSSI_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid_i,
    input  logic [7:0]          cmd_byte_i,
    input  logic                cs_wake_i,
    input  logic                wake_timer_i,
    input  logic                stream_mode_i,
    input  logic                turn_rx2tx_i,
    input  logic                turn_tx2rx_i,
    input  logic                ext_pa_cfg_i,
    input  logic                ext_lna_cfg_i,
    input  logic                eof_irq_en_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic                eof_tx_i,
    input  logic                eof_rx_i,
    input  logic                vco_done_i,
    input  logic                ramp_done_i,
    input  logic [RSSI_W-1:0]   rssi_i,
    output logic [2:0]          state_o,
    output logic                cmd_ready_o,
    output logic                err_o,
    output logic                eof_irq_o,
    output logic                synth_pwr_o,
    output logic                rx_pwr_o,
    output logic                chan_load_o,
    output logic                bw_set_o,
    output logic                vco_cal_start_o,
    output logic                dig_rx_en_o,
    output logic                dig_tx_en_o,
    output logic                ext_lna_o,
    output logic                ext_pa_o,
    output logic                pa_ramp_up_o,
    output logic                pa_ramp_down_o,
    output logic [RSSI_W-1:0]   rssi_hold_o
);

    rs_state_t state_q, tgt, eof_tgt, start_to, eng_dest;
    logic      err_q, irq_q, legal, need_seq, hw_rst, idle;
    logic      cmd_go, eof_go, busy, eng_done, eng_fail;

    rss_cmd_check u_check (
        .op_i       (cmd_byte_i),
        .cur_i      (state_q),
        .legal_o    (legal),
        .need_seq_o (need_seq),
        .target_o   (tgt)
    );

    assign hw_rst  = cmd_valid_i && (cmd_byte_i == OP_HWRST);
    assign idle    = (state_q != ST_SLEEP) && !busy;
    assign cmd_go  = idle && cmd_valid_i && !hw_rst && legal && need_seq;
    assign eof_go  = idle && !cmd_valid_i && !stream_mode_i &&
                     (((state_q == ST_TX) && eof_tx_i) || ((state_q == ST_RX) && eof_rx_i));
    assign eof_tgt = (state_q == ST_TX) ? (turn_tx2rx_i ? ST_RX : ST_ON)
                                        : (turn_rx2tx_i ? ST_TX : ST_ON);
    assign start_to = cmd_go ? tgt : eof_tgt;

    rss_seq_engine #(
        .SETTLE_W (SETTLE_W),
        .TMO_CYC  (TMO_CYC),
        .RSSI_W   (RSSI_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort_i     (hw_rst),
        .start_i     (cmd_go || eof_go),
        .from_i      (state_q),
        .to_i        (start_to),
        .settle_i    (settle_cycles_i),
        .cfg_pa_i    (ext_pa_cfg_i),
        .cfg_lna_i   (ext_lna_cfg_i),
        .vco_done_i  (vco_done_i),
        .ramp_done_i (ramp_done_i),
        .rssi_i      (rssi_i),
        .busy_o      (busy),
        .done_o      (eng_done),
        .fail_o      (eng_fail),
        .dest_o      (eng_dest),
        .synth_o     (synth_pwr_o),
        .rx_pwr_o    (rx_pwr_o),
        .dig_rx_o    (dig_rx_en_o),
        .dig_tx_o    (dig_tx_en_o),
        .lna_o       (ext_lna_o),
        .pa_o        (ext_pa_o),
        .chan_o      (chan_load_o),
        .bw_o        (bw_set_o),
        .vco_start_o (vco_cal_start_o),
        .ramp_up_o   (pa_ramp_up_o),
        .ramp_dn_o   (pa_ramp_down_o),
        .rssi_q_o    (rssi_hold_o)
    );

    // Track the reported state, the sticky error and the frame interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (hw_rst) begin
                state_q <= ST_SLEEP;
            end else if (state_q == ST_SLEEP) begin
                if (cs_wake_i || wake_timer_i) state_q <= ST_OFF;
                if (cmd_valid_i) err_q <= 1'b1;
            end else if (eng_done) begin
                state_q <= eng_dest;
                if (cmd_valid_i) err_q <= 1'b1;
            end else if (eng_fail) begin
                state_q <= ST_ON;
                err_q   <= 1'b1;
            end else if (busy) begin
                if (cmd_valid_i) err_q <= 1'b1;
            end else if (cmd_valid_i) begin
                if (!legal)         err_q   <= 1'b1;
                else if (!need_seq) state_q <= tgt;
            end else if (eof_go) begin
                irq_q <= eof_irq_en_i;
            end
        end
    end

    assign state_o     = state_q;
    assign cmd_ready_o = idle;
    assign err_o       = err_q;
    assign eof_irq_o   = irq_q;

    // R11: nothing in the RF path stays powered in sleep.
    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!synth_pwr_o && !rx_pwr_o && !ext_pa_o));
    // R12: the host is never told ready while a step is issuing actions.
    p_ready_low_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        vco_cal_start_o |-> !cmd_ready_o);
    // R4: a settled receive state has the digital receiver running.
    p_rx_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RX) && cmd_ready_o) |-> (dig_rx_en_o && synth_pwr_o));
    // R5: a settled transmit state has the transmit path running.
    p_tx_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TX) && cmd_ready_o) |-> (dig_tx_en_o && synth_pwr_o));

endmodule

// File: tb/radio_state_seq_bench.sv
module radio_state_seq_bench;
    import rss_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0, cmd_valid_i = 1'b0, cs_wake_i = 1'b0, wake_timer_i = 1'b0;
    logic [7:0] cmd_byte_i = 8'h00, settle_cycles_i = 8'd2, rssi_i = 8'h00;
    logic       stream_mode_i = 1'b0, turn_rx2tx_i = 1'b0, turn_tx2rx_i = 1'b0;
    logic       ext_pa_cfg_i = 1'b1, ext_lna_cfg_i = 1'b1, eof_irq_en_i = 1'b0;
    logic       eof_tx_i = 1'b0, eof_rx_i = 1'b0, vco_done_i = 1'b0, ramp_done_i = 1'b0;
    logic [2:0] state_o;
    logic       cmd_ready_o, err_o, eof_irq_o, synth_pwr_o, rx_pwr_o, chan_load_o, bw_set_o;
    logic       vco_cal_start_o, dig_rx_en_o, dig_tx_en_o, ext_lna_o, ext_pa_o;
    logic       pa_ramp_up_o, pa_ramp_down_o;
    logic [7:0] rssi_hold_o;

    radio_state_seq u_radio_state_seq (.*);

    int    total = 0, bad = 0, irq_cnt = 0, gap = 0, last_gap = 0, vco_cd = 0, ramp_cd = 0;
    bit    mute_vco = 1'b0;
    string evlog = "";
    logic [7:0] p_rssi = 8'h00;
    logic p_syn = 0, p_rx = 0, p_drx = 0, p_dtx = 0, p_lna = 0, p_pa = 0;

    // Event log of control edges plus handshake responder.
    always @(negedge clk) begin
        if (rssi_hold_o != p_rssi)      evlog = {evlog, "Q"};
        if (p_lna && !ext_lna_o)        evlog = {evlog, "l"};
        if (p_drx && !dig_rx_en_o)      evlog = {evlog, "d"};
        if (p_rx && !rx_pwr_o)          evlog = {evlog, "r"};
        if (pa_ramp_down_o)             evlog = {evlog, "m"};
        if (p_pa && !ext_pa_o)          evlog = {evlog, "p"};
        if (p_dtx && !dig_tx_en_o)      evlog = {evlog, "t"};
        if (p_syn && !synth_pwr_o)      evlog = {evlog, "s"};
        if (!p_syn && synth_pwr_o)      evlog = {evlog, "S"};
        if (!p_rx && rx_pwr_o)          evlog = {evlog, "R"};
        if (chan_load_o)                evlog = {evlog, "C"};
        if (bw_set_o)                   evlog = {evlog, "B"};
        if (vco_cal_start_o)            evlog = {evlog, "V"};
        if (!p_drx && dig_rx_en_o)      evlog = {evlog, "D"};
        if (!p_lna && ext_lna_o)        evlog = {evlog, "L"};
        if (!p_dtx && dig_tx_en_o)      evlog = {evlog, "T"};
        if (!p_pa && ext_pa_o)          evlog = {evlog, "P"};
        if (pa_ramp_up_o)               evlog = {evlog, "M"};
        if (eof_irq_o) irq_cnt++;
        if (vco_done_i) gap = 0; else gap++;
        if (!p_drx && dig_rx_en_o) last_gap = gap;
        p_rssi = rssi_hold_o; p_syn = synth_pwr_o; p_rx = rx_pwr_o; p_drx = dig_rx_en_o;
        p_dtx = dig_tx_en_o; p_lna = ext_lna_o; p_pa = ext_pa_o;
        vco_done_i = 1'b0;
        ramp_done_i = 1'b0;
        if (vco_cd > 0) begin vco_cd--; if (vco_cd == 0) vco_done_i = 1'b1; end
        if (ramp_cd > 0) begin ramp_cd--; if (ramp_cd == 0) ramp_done_i = 1'b1; end
        if (vco_cal_start_o && !mute_vco) vco_cd = 3;
        if (pa_ramp_up_o || pa_ramp_down_o) ramp_cd = 4;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_seq(string req, string exp);
        total++;
        if (evlog != exp) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", req, evlog, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stream_mode_i = 0; turn_rx2tx_i = 0; turn_tx2rx_i = 0;
        ext_pa_cfg_i = 1; ext_lna_cfg_i = 1; eof_irq_en_i = 0; settle_cycles_i = 8'd2;
        mute_vco = 0; rssi_i = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        evlog = ""; irq_cnt = 0;
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_byte_i = b;
        @(negedge clk);
        cmd_valid_i = 1'b0;
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 1000 && !cmd_ready_o; n++) @(negedge clk);
    endtask

    task automatic go(logic [7:0] b);
        send(b);
        wait_ready();
    endtask

    task automatic t_reset();
        do_reset();
        chk(state_o == 3'd1, "R1 state", state_o, 1);
        chk(cmd_ready_o && !err_o && !eof_irq_o, "R1 flags", {cmd_ready_o, err_o, eof_irq_o}, 3'b100);
        chk({synth_pwr_o, rx_pwr_o, dig_rx_en_o, dig_tx_en_o, ext_pa_o, ext_lna_o} == 0,
            "R1 controls", {synth_pwr_o, rx_pwr_o, ext_pa_o}, 0);
    endtask

    task automatic t_direct();
        do_reset();
        send(OP_ON);    chk(state_o == 3'd2, "R2 off->on", state_o, 2);
        send(OP_OFF);   chk(state_o == 3'd1, "R2 on->off", state_o, 1);
        send(OP_ON);
        send(OP_SLEEP); chk(state_o == 3'd0, "R2 on->sleep", state_o, 0);
        chk(!err_o, "R2 no error", err_o, 0);
    endtask

    task automatic t_illegal();
        do_reset();
        send(OP_RX);
        chk(state_o == 3'd1 && err_o, "R3 rx from off", {state_o, err_o}, 4'b0011);
        chk(!synth_pwr_o, "R3 no action", synth_pwr_o, 0);
        do_reset();
        send(8'h37);
        chk(state_o == 3'd1 && err_o, "R3 unknown op", {state_o, err_o}, 4'b0011);
    endtask

    task automatic t_rx();
        do_reset();
        send(OP_ON); evlog = "";
        go(OP_RX);
        chk_seq("R4 on->rx order", "SRCBVDL");
        chk(state_o == 3'd3, "R4 state", state_o, 3);
        evlog = "";
        go(OP_RX);
        chk_seq("R8 retune order", "ldrRCBVDL");
        chk(state_o == 3'd3, "R8 state", state_o, 3);
        evlog = ""; rssi_i = 8'h5A;
        go(OP_ON);
        chk_seq("R7 rx->on order", "Qldrs");
        chk(rssi_hold_o == 8'h5A, "R7 rssi", rssi_hold_o, 8'h5A);
        chk(state_o == 3'd2, "R7 state", state_o, 2);
    endtask

    task automatic t_tx();
        do_reset();
        send(OP_ON); evlog = "";
        go(OP_TX);
        chk_seq("R5 on->tx order", "SCBVTPM");
        chk(state_o == 3'd4, "R5 state", state_o, 4);
        evlog = "";
        go(OP_ON);
        chk_seq("R6 tx->on order", "mpts");
        chk(state_o == 3'd2 && !ext_pa_o, "R6 state", {state_o, ext_pa_o}, 4'b0100);
        ext_pa_cfg_i = 0; evlog = "";
        go(OP_TX);
        chk_seq("R5 no ext pa", "SCBVTM");
    endtask

    task automatic pulse_eof(bit tx);
        @(negedge clk);
        if (tx) eof_tx_i = 1'b1; else eof_rx_i = 1'b1;
        @(negedge clk);
        eof_tx_i = 1'b0; eof_rx_i = 1'b0;
    endtask

    task automatic t_eof();
        do_reset();
        eof_irq_en_i = 1;
        send(OP_ON); go(OP_RX);
        pulse_eof(0); wait_ready();
        chk(state_o == 3'd2, "R9 rx eof to on", state_o, 2);
        chk(irq_cnt == 1, "R9 irq", irq_cnt, 1);
        turn_tx2rx_i = 1;
        go(OP_TX); evlog = "";
        pulse_eof(1); wait_ready();
        chk_seq("R9 turnaround order", "mptsSRCBVDL");
        chk(state_o == 3'd3 && irq_cnt == 2, "R9 turnaround", {state_o, 4'(irq_cnt)}, 7'h32);
    endtask

    task automatic t_stream();
        do_reset();
        stream_mode_i = 1; eof_irq_en_i = 1;
        send(OP_ON); go(OP_RX);
        pulse_eof(0);
        repeat (20) @(negedge clk);
        chk(state_o == 3'd3 && cmd_ready_o, "R10 stays rx", state_o, 3);
        chk(irq_cnt == 0, "R10 no irq", irq_cnt, 0);
        go(OP_ON);
        chk(state_o == 3'd2, "R10 on exits", state_o, 2);
    endtask

    task automatic t_hwreset();
        do_reset();
        send(OP_ON); send(OP_RX);
        repeat (2) @(negedge clk);
        send(OP_HWRST);
        chk(state_o == 3'd0, "R11 to sleep", state_o, 0);
        chk(!synth_pwr_o && !rx_pwr_o && !cmd_ready_o, "R11 cleared",
            {synth_pwr_o, rx_pwr_o, cmd_ready_o}, 0);
        repeat (10) @(negedge clk);
        chk(!synth_pwr_o && !dig_rx_en_o, "R11 sequence dead", synth_pwr_o, 0);
        @(negedge clk); wake_timer_i = 1;
        @(negedge clk); wake_timer_i = 0;
        chk(state_o == 3'd1 && cmd_ready_o, "R11 wake", state_o, 1);
    endtask

    task automatic t_busy();
        do_reset();
        send(OP_ON); send(OP_RX);
        chk(!cmd_ready_o, "R12 ready low", cmd_ready_o, 0);
        send(OP_ON);
        wait_ready();
        chk(state_o == 3'd3 && err_o, "R12 dropped", {state_o, err_o}, 4'b0111);
    endtask

    task automatic t_settle();
        int g1;
        do_reset();
        settle_cycles_i = 8'd2;
        send(OP_ON); go(OP_RX);
        g1 = last_gap;
        go(OP_ON);
        settle_cycles_i = 8'd7;
        go(OP_RX);
        chk(last_gap - g1 == 5, "R13 settle delta", last_gap - g1, 5);
    endtask

    task automatic t_timeout();
        do_reset();
        send(OP_ON);
        mute_vco = 1;
        go(OP_RX);
        chk(state_o == 3'd2 && err_o, "R14 to on with error", {state_o, err_o}, 4'b0101);
        chk(!synth_pwr_o && !rx_pwr_o, "R14 cleared", {synth_pwr_o, rx_pwr_o}, 0);
        mute_vco = 0;
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_direct();
        t_illegal();
        t_rx();
        t_tx();
        t_eof();
        t_stream();
        t_hwreset();
        t_busy();
        t_settle();
        t_timeout();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule